// File: doc/BRIEF.md
# Frame-Synchronised PCM Serial Port

This block is the digital serial side of a telephony voice codec. In each 8 kHz frame it sends one 8-bit PCM sample on a transmit data line and collects one 8-bit sample from a receive data line. Each direction has its own frame-sync pulse and bit clock. The transmit line is driven only during its slot and is otherwise high impedance, reported through an output-enable. An active-low slot flag marks the transmit slot. The flag is modelled as the level an open-drain pin would show: 0 means pulled low, 1 means released.

All pins are oversampled by the system clock `clk_i`, which must run well above the fastest bit clock. The block also watches the receive master clock. If that clock is held low, the receive side switches to the transmit bit clock, and the receive bit-clock pin is read as a static master-clock rate select. If that clock is held high, the port powers down. A master clock counts as held once 32 rising edges of the transmit master clock pass without any edge on it. Companding, filtering and all analog functions are outside this block.

Top module: `pcm_serial_port`

## Requirements
- R1: The first bit-clock rise at which the transmit frame sync is seen high, after being low at the previous rise, starts a slot. The sample goes out MSB first, one bit per bit-clock period, and each bit changes on a rising bit-clock edge.
- R2: `dx_oe_o` is high for exactly 8 bit-clock periods from the slot start and low at all other times (high impedance).
- R3: `tslot_n_o` is 0 (pulled low) exactly while the transmit slot is active, and 1 (released) otherwise.
- R4: After a receive frame-sync leading edge, the next 8 falling bit-clock edges sample `dr_i`, MSB first. The byte then appears on `rx_byte_o` together with a `rx_valid_o` pulse one system clock long, and `rx_byte_o` holds its value until the next such pulse.
- R5: A frame may span from 8 to 256 bit-clock periods. Data-line activity after the eighth bit has no effect, and it produces no extra strobe.
- R6: When the receive master clock stays low for 32 transmit-master-clock rises, `sync_mode_o` becomes 1 and the receive path runs on the transmit bit clock. In that mode `rate_sel_o` follows the receive bit-clock pin: 1 selects 2.048 MHz and 0 selects 1.536/1.544 MHz. Outside that mode `rate_sel_o` is 0.
- R7: When the receive master clock stays high for 32 transmit-master-clock rises, `pdn_o` becomes 1. While it is 1, `dx_oe_o` stays 0, `tslot_n_o` stays 1 and no `rx_valid_o` pulse occurs.
- R8: Fewer than 32 transmit-master-clock rises without a receive-master-clock edge change no mode. A single receive-master-clock edge returns the port to asynchronous mode (`sync_mode_o` = 0, `pdn_o` = 0) within 3 system clocks.
- R9: After reset, `dx_oe_o`, `rx_valid_o`, `sync_mode_o`, `pdn_o` and `rate_sel_o` are 0 and `tslot_n_o` is 1.
- R10: The transmit byte is captured at the slot start. Changes on `tx_byte_i` during the slot do not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_tx_i | input | 1 | Transmit master clock |
| mclk_rx_i | input | 1 | Receive master clock / mode pin |
| bclk_tx_i | input | 1 | Transmit bit clock |
| bclk_rx_i | input | 1 | Receive bit clock / rate select |
| fs_tx_i | input | 1 | Transmit frame sync |
| fs_rx_i | input | 1 | Receive frame sync |
| dr_i | input | 1 | Serial receive data |
| tx_byte_i | input | 8 | Sample to transmit |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Transmit output enable |
| tslot_n_o | output | 1 | Slot flag, 0 = pulled low |
| rx_byte_o | output | 8 | Last received sample |
| rx_valid_o | output | 1 | One-cycle receive strobe |
| sync_mode_o | output | 1 | Shared bit-clock mode active |
| pdn_o | output | 1 | Power-down active |
| rate_sel_o | output | 1 | Master-clock rate select in shared mode |

## Verification
The bench varies the frame length. With 64 kHz frames the slots run back to back, and with longer frames random data follows the eighth bit. A port that counted more than eight bits would either keep the enable high or raise a second strobe. It changes `tx_byte_i` in the middle of a slot, so a design that shifts straight from the input instead of a captured copy would send corrupted bits. The mode detector is probed on both sides of the 32-rise threshold and again immediately after one edge on the receive master clock. An early or sticky detector would switch modes at the wrong moment. Powered-down frames must leave the transmit line quiet and raise no strobe.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned PIN_N   = 7;
  localparam int unsigned PIN_MTX = 0;
  localparam int unsigned PIN_MRX = 1;
  localparam int unsigned PIN_BTX = 2;
  localparam int unsigned PIN_BRX = 3;
  localparam int unsigned PIN_FTX = 4;
  localparam int unsigned PIN_FRX = 5;
  localparam int unsigned PIN_DR  = 6;

  typedef enum logic [1:0] {
    MODE_ASYNC  = 2'd0,
    MODE_SHARED = 2'd1,
    MODE_PDN    = 2'd2
  } clk_mode_e;
endpackage

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign lvl_o  = s1_q;
  assign rise_o = s1_q & ~s2_q;
  assign fall_o = ~s1_q & s2_q;
endmodule

// File: rtl/pcm_mode_det.sv
module pcm_mode_det
  import pcm_port_pkg::*;
#(
  parameter int unsigned STATIC_CYC = 32
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      mtx_rise_i,
  input  logic      mrx_edge_i,
  input  logic      mrx_lvl_i,
  output clk_mode_e mode_o
);
  localparam int unsigned CW = $clog2(STATIC_CYC + 1);

  logic [CW-1:0] quiet_q;
  logic          held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      quiet_q <= '0;
    else if (mrx_edge_i)                              quiet_q <= '0;
    else if (mtx_rise_i && quiet_q != CW'(STATIC_CYC)) quiet_q <= quiet_q + 1'b1;
  end

  assign held   = (quiet_q == CW'(STATIC_CYC));
  assign mode_o = !held ? MODE_ASYNC : (mrx_lvl_i ? MODE_PDN : MODE_SHARED);

  p_edge_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrx_edge_i |=> mode_o == MODE_ASYNC);
  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_q <= CW'(STATIC_CYC));
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bclk_rise_i,
  input  logic              fs_lvl_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              dx_o,
  output logic              oe_o
);
  localparam int unsigned BW = $clog2(BYTE_W);

  logic              fs_prev_q, active_q;
  logic [BW-1:0]     idx_q;
  logic [BYTE_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_prev_q <= 1'b0;
      active_q  <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
    end else begin
      if (bclk_rise_i) fs_prev_q <= fs_lvl_i;
      if (!en_i) begin
        active_q <= 1'b0;
      end else if (bclk_rise_i) begin
        if (fs_lvl_i && !fs_prev_q) begin
          active_q <= 1'b1;
          sh_q     <= byte_i;
          idx_q    <= '0;
        end else if (active_q) begin
          sh_q <= sh_q << 1;
          if (idx_q == BW'(BYTE_W - 1)) active_q <= 1'b0;
          else                          idx_q    <= idx_q + 1'b1;
        end
      end
    end
  end

  assign dx_o = sh_q[BYTE_W-1];
  assign oe_o = active_q;

  p_quiet_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !oe_o);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && en_i && !bclk_rise_i) |=> $stable(dx_o));
  p_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> ($past(!en_i) || $past(idx_q == BW'(BYTE_W - 1))));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              bclk_rise_i,
  input  logic              bclk_fall_i,
  input  logic              fs_lvl_i,
  input  logic              dr_lvl_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int unsigned BW = $clog2(BYTE_W);

  logic              fs_prev_q, armed_q, valid_q;
  logic [BW-1:0]     idx_q;
  logic [BYTE_W-1:0] sh_q, byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_prev_q <= 1'b0;
      armed_q   <= 1'b0;
      valid_q   <= 1'b0;
      idx_q     <= '0;
      sh_q      <= '0;
      byte_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (bclk_rise_i) fs_prev_q <= fs_lvl_i;
      if (!en_i) begin
        armed_q <= 1'b0;
      end else if (bclk_rise_i && fs_lvl_i && !fs_prev_q) begin
        armed_q <= 1'b1;
        idx_q   <= '0;
      end else if (bclk_fall_i && armed_q) begin
        sh_q <= {sh_q[BYTE_W-2:0], dr_lvl_i};
        if (idx_q == BW'(BYTE_W - 1)) begin
          armed_q <= 1'b0;
          byte_q  <= {sh_q[BYTE_W-2:0], dr_lvl_i};
          valid_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;

  p_strobe_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_byte_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(byte_o));
  p_no_strobe_pd_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned STATIC_CYC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclk_tx_i,
  input  logic              mclk_rx_i,
  input  logic              bclk_tx_i,
  input  logic              bclk_rx_i,
  input  logic              fs_tx_i,
  input  logic              fs_rx_i,
  input  logic              dr_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  output logic              dx_o,
  output logic              dx_oe_o,
  output logic              tslot_n_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              sync_mode_o,
  output logic              pdn_o,
  output logic              rate_sel_o
);
  logic [PIN_N-1:0] pin_raw, lvl, rise, fall;
  clk_mode_e        mode;
  logic             en, shared, rx_rise, rx_fall, tx_oe;

  assign pin_raw[PIN_MTX] = mclk_tx_i;
  assign pin_raw[PIN_MRX] = mclk_rx_i;
  assign pin_raw[PIN_BTX] = bclk_tx_i;
  assign pin_raw[PIN_BRX] = bclk_rx_i;
  assign pin_raw[PIN_FTX] = fs_tx_i;
  assign pin_raw[PIN_FRX] = fs_rx_i;
  assign pin_raw[PIN_DR]  = dr_i;

  pcm_edge_det #(.W(PIN_N)) i_pins (
    .clk_i, .rst_ni, .pin_i(pin_raw), .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pcm_mode_det #(.STATIC_CYC(STATIC_CYC)) i_mode (
    .clk_i, .rst_ni,
    .mtx_rise_i(rise[PIN_MTX]),
    .mrx_edge_i(rise[PIN_MRX] | fall[PIN_MRX]),
    .mrx_lvl_i (lvl[PIN_MRX]),
    .mode_o    (mode)
  );

  assign en      = (mode != MODE_PDN);
  assign shared  = (mode == MODE_SHARED);
  assign rx_rise = shared ? rise[PIN_BTX] : rise[PIN_BRX];
  assign rx_fall = shared ? fall[PIN_BTX] : fall[PIN_BRX];

  pcm_tx_slot #(.BYTE_W(BYTE_W)) i_tx (
    .clk_i, .rst_ni, .en_i(en),
    .bclk_rise_i(rise[PIN_BTX]),
    .fs_lvl_i   (lvl[PIN_FTX]),
    .byte_i     (tx_byte_i),
    .dx_o       (dx_o),
    .oe_o       (tx_oe)
  );

  pcm_rx_slot #(.BYTE_W(BYTE_W)) i_rx (
    .clk_i, .rst_ni, .en_i(en),
    .bclk_rise_i(rx_rise),
    .bclk_fall_i(rx_fall),
    .fs_lvl_i   (lvl[PIN_FRX]),
    .dr_lvl_i   (lvl[PIN_DR]),
    .byte_o     (rx_byte_o),
    .valid_o    (rx_valid_o)
  );

  assign dx_oe_o     = tx_oe;
  assign tslot_n_o   = ~tx_oe;
  assign sync_mode_o = shared;
  assign pdn_o       = (mode == MODE_PDN);
  assign rate_sel_o  = shared & lvl[PIN_BRX];

  p_pd_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_o |=> tslot_n_o);
  p_rate_async_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_mode_o |-> !rate_sel_o);
endmodule

// File: tb/test_pcm_serial_port.sv
module test_pcm_serial_port;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mclk_tx = 1'b0, mclk_rx = 1'b0;
  logic       bclk_tx = 1'b0, bclk_rx = 1'b0;
  logic       fs_tx = 1'b0, fs_rx = 1'b0, dr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       dx, dx_oe, tslot_n, rx_valid, sync_mode, pdn, rate_sel;
  logic [7:0] rx_byte;

  int         n_run = 0, n_fail = 0;
  int         vcnt = 0;
  logic [7:0] last_rx = 8'h00;
  int         mrx_mode = 0;   // 0 toggle, 1 hold low, 2 hold high
  int         prev_n = 99;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pcm_serial_port i_pcm_serial_port (
    .clk_i(clk), .rst_ni(rst_ni),
    .mclk_tx_i(mclk_tx), .mclk_rx_i(mclk_rx),
    .bclk_tx_i(bclk_tx), .bclk_rx_i(bclk_rx),
    .fs_tx_i(fs_tx), .fs_rx_i(fs_rx), .dr_i(dr),
    .tx_byte_i(tx_byte),
    .dx_o(dx), .dx_oe_o(dx_oe), .tslot_n_o(tslot_n),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .sync_mode_o(sync_mode), .pdn_o(pdn), .rate_sel_o(rate_sel)
  );

  initial forever begin
    repeat (4) @(negedge clk);
    mclk_tx = ~mclk_tx;
  end

  initial forever begin
    repeat (5) @(negedge clk);
    if (mrx_mode == 0) mclk_rx = ~mclk_rx;
    else               mclk_rx = (mrx_mode == 2);
  end

  always @(negedge clk) if (rst_ni && rx_valid) begin
    vcnt++;
    last_rx = rx_byte;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] txb, input logic [7:0] rxb, input int nper,
                       input bit shared, input bit pd);
    int v0 = vcnt;
    for (int p = 0; p < nper; p++) begin
      if (p == 0) begin fs_tx = 1'b1; fs_rx = 1'b1; tx_byte = txb; end
      if (p == 1) begin fs_tx = 1'b0; fs_rx = 1'b0; tx_byte = ~txb; end // R10
      wclk(4);
      if (p == 0 && prev_n > 8) chk(dx_oe == 1'b0, "R2 idle before slot", dx_oe, 0);
      wclk(4);
      bclk_tx = 1'b1;
      if (!shared) bclk_rx = 1'b1;
      dr = (p < 8) ? rxb[7-p] : 1'($urandom);  // R5 noise after bit 8
      wclk(6);
      begin
        bit exp_oe = !pd && p < 8;
        chk(dx_oe == exp_oe, "R2 enable window", dx_oe, exp_oe);
        chk(tslot_n == !exp_oe, "R3 slot flag", tslot_n, !exp_oe);
        if (exp_oe) chk(dx == txb[7-p], "R1 R10 serial bit", dx, txb[7-p]);
      end
      wclk(2);
      bclk_tx = 1'b0;
      if (!shared) bclk_rx = 1'b0;
      wclk(4);
    end
    wclk(4);
    chk(vcnt - v0 == (pd ? 0 : 1), pd ? "R7 no strobe" : "R4 R5 one strobe", vcnt - v0, pd ? 0 : 1);
    if (!pd) chk(last_rx == rxb, "R4 received byte", last_rx, rxb);
    prev_n = nper;
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    wclk(3);
    chk(dx_oe == 1'b0 && tslot_n == 1'b1, "R9 reset tx", {dx_oe, tslot_n}, 2'b01);
    chk(!rx_valid && !sync_mode && !pdn && !rate_sel, "R9 reset flags",
        {rx_valid, sync_mode, pdn, rate_sel}, 0);
    rst_ni = 1'b1;
    wclk(4);

    // directed: back-to-back minimal frames, then long ones
    frame(8'hA5, 8'h3C, 8, 0, 0);
    frame(8'h01, 8'h80, 8, 0, 0);
    frame(8'hFF, 8'h00, 40, 0, 0);
    frame(8'h00, 8'hFF, 12, 0, 0);
    for (int i = 0; i < 12; i++)
      frame(8'($urandom), 8'($urandom), 8 + int'($urandom % 33), 0, 0);
    chk(rate_sel == 1'b0, "R6 rate_sel low in async", rate_sel, 0);

    // shared clock mode: below and above threshold
    mrx_mode = 1;
    wclk(160);
    chk(sync_mode == 1'b0, "R8 below threshold", sync_mode, 0);
    wclk(200);
    chk(sync_mode == 1'b1 && pdn == 1'b0, "R6 shared mode entered", {sync_mode, pdn}, 2'b10);
    bclk_rx = 1'b1; wclk(4);
    chk(rate_sel == 1'b1, "R6 rate 2.048", rate_sel, 1);
    frame(8'h5A, 8'hC3, 10, 1, 0);
    bclk_rx = 1'b0; wclk(4);
    chk(rate_sel == 1'b0, "R6 rate 1.544", rate_sel, 0);
    for (int i = 0; i < 4; i++)
      frame(8'($urandom), 8'($urandom), 8 + int'($urandom % 20), 1, 0);

    // one edge returns to async
    mrx_mode = 0;
    wclk(8);
    chk(sync_mode == 1'b0 && pdn == 1'b0, "R8 edge exits mode", {sync_mode, pdn}, 0);
    frame(8'h96, 8'h69, 9, 0, 0);

    // power-down
    mrx_mode = 2;
    wclk(360);
    chk(pdn == 1'b1 && sync_mode == 1'b0, "R7 power-down entered", {pdn, sync_mode}, 2'b10);
    frame(8'hE7, 8'h18, 10, 0, 1);
    frame(8'h7E, 8'h81, 8, 0, 1);
    mrx_mode = 0;
    wclk(8);
    chk(pdn == 1'b0, "R8 edge exits power-down", pdn, 0);
    prev_n = 99;
    frame(8'h42, 8'h24, 9, 0, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule